// File: doc/BRIEF.md
# ATM Transmit Cell Header Processor

This block rewrites the header of outbound 53-octet ATM cells on their way to the line. Each cell arrives as a byte stream. A byte strobe qualifies each byte, a start flag marks the first octet, and a class flag taken with that first octet tells valid cells from idle ones. Every byte comes out one clock later.

Along the way the block can do four things to a cell:
- It can replace the generic-flow-control nibble of octet 0 with four bits collected from a serial input.
- It checks the integrity byte that valid cells carry in octet 4.
- It can overwrite octet 4 with a CRC-8 header check sequence computed over octets 0..3, with an optional 0x55 coset.
- It can scramble the 48 payload octets with a self-synchronizing x^43+1 scrambler.

An 8-bit control register selects these features. It also holds a sticky integrity-error flag, which is cleared by reading the register and can drive an interrupt output.

Top module: `txcell_hdr_proc`

## Requirements
- R1: After reset the control register reads 0xF2. Bit 7 is scramble, bit 6 is coset, bit 5 is the valid-cell check-byte insert, bit 4 is the constant-pattern select, bit 3 is flow-control insert, bit 2 is the interrupt enable, bit 1 is the idle-cell check-byte insert, and bit 0 is the error flag.
- R2: A register write updates bits 7..1. Bit 0 of the write data is ignored.
- R3: Every accepted byte appears on the output one clock later with its strobe. A byte accepted with the start flag comes out with the output start flag.
- R4: In a valid cell, octet 4 is compared with the expected pattern and a mismatch sets bit 0. With bit 4 at 1 the expected value is always 0x55. With bit 4 at 0 it is 0x55 for the first valid cell after reset and then alternates 0x55/0xAA from one valid cell to the next. Idle cells are not checked and do not advance the alternation.
- R5: Bit 0 stays set until the register is read. The read returns the set value, and the flag is clear from the next cycle on.
- R6: The interrupt output is high exactly when bit 2 and bit 0 are both 1.
- R7: Octet 4 is replaced by the CRC-8 (generator x^8+x^2+x+1, preset zero) of the outbound octets 0..3 when the insert enable of the cell's class is 1 (bit 5 for valid cells, bit 1 for idle cells). Otherwise octet 4 passes through unchanged.
- R8: With bit 6 at 1 the inserted check byte is the CRC XOR 0x55. With bit 6 at 0 it is the plain CRC.
- R9: The serial flow-control input is sampled on octets 0..3 of each cell, with the first sample being the MSB. With bit 3 at 1, the upper nibble of octet 0 of the following cell is replaced by that nibble. The nibble is zero before the first complete cell.
- R10: With bit 7 at 1, payload octets 5..52 are scrambled MSB first: each output bit is the input bit XOR the output bit 43 bits earlier. The scrambler state starts at zero and carries over from cell to cell. Header octets are never scrambled. With bit 7 at 0, payload passes through and the state holds.
- R11: Header octets 1..3 always pass unchanged, and so does octet 0 when bit 3 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte strobe |
| inSoc | input | 1 | Input byte is octet 0 of a cell |
| inIdle | input | 1 | Cell is idle; sampled with inSoc |
| inData | input | 8 | Input byte |
| gfcIn | input | 1 | Serial flow-control bit |
| outValid | output | 1 | Output byte strobe |
| outSoc | output | 1 | Output byte is octet 0 |
| outData | output | 8 | Output byte |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| regRdEn | input | 1 | Control register read strobe; clears bit 0 |
| regRdData | output | 8 | Control register contents |
| irq | output | 1 | Integrity-error interrupt |

## Verification
The hardest situation to reach is a scrambled payload whose expected value depends on 43 bits of history spread across several cells. At the same time, the alternating integrity pattern must stay in step across idle cells that are mixed in. The stimulus therefore sends long runs of random cells back to back. Each run has a random class, random flow-control bits and randomly correct or corrupted octet 4, under random control settings. A bench model carries the scrambler state, the alternation phase and the held flow-control nibble from cell to cell. Directed cells cover reset, write masking of bit 0, the read-clear and the interrupt gating.

// File: rtl/hdrPkg.sv
package hdrPkg;
  typedef struct packed {
    logic first;    // octet 0 accepted
    logic hdr;      // octets 0..3 accepted
    logic hecSlot;  // octet 4 accepted
    logic payload;  // octets 5..52 accepted
    logic last;     // octet 52 accepted
    logic hecIns;   // insert check byte for this cell's class
    logic coset;
    logic scramble;
    logic gfcIns;
  } strobeT;
endpackage

// File: rtl/cellCtrl.sv
module cellCtrl
  import hdrPkg::*;
#(
  parameter int CELL_LEN = 53,
  parameter int HDR_LEN  = 5,
  parameter logic [7:0] PAT_A = 8'h55
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSoc,
  input  logic       inIdle,
  input  logic [7:0] inData,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  output logic [7:0] regRdData,
  output logic       irq,
  output strobeT     strobe
);
  localparam int CW = $clog2(CELL_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(CELL_LEN - 1);
  localparam logic [CW-1:0] HEC  = CW'(HDR_LEN - 1);

  logic [7:1] ctrlBits;
  logic status, cellIdle, altPhase, curIdle, errSet;
  logic [CW-1:0] cnt, idx;
  logic [7:0] expPat;

  assign idx     = inSoc ? '0 : cnt;
  assign curIdle = inSoc ? inIdle : cellIdle;
  assign expPat  = (ctrlBits[4] || !altPhase) ? PAT_A : ~PAT_A;

  always_comb begin
    strobe.first    = inValid && idx == '0;
    strobe.hdr      = inValid && idx < HEC;
    strobe.hecSlot  = inValid && idx == HEC;
    strobe.payload  = inValid && idx > HEC && idx <= LAST;
    strobe.last     = inValid && idx == LAST;
    strobe.hecIns   = curIdle ? ctrlBits[1] : ctrlBits[5];
    strobe.coset    = ctrlBits[6];
    strobe.scramble = ctrlBits[7];
    strobe.gfcIns   = ctrlBits[3];
  end

  assign errSet    = strobe.hecSlot && !curIdle && inData != expPat;
  assign regRdData = {ctrlBits, status};
  assign irq       = ctrlBits[2] & status;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlBits <= 7'b1111001;
      status   <= 1'b0;
      cnt      <= CW'(CELL_LEN);
      cellIdle <= 1'b0;
      altPhase <= 1'b0;
    end else begin
      if (regWrEn) ctrlBits <= regWrData[7:1];
      if (errSet) status <= 1'b1;
      else if (regRdEn) status <= 1'b0;
      if (inValid) begin
        cellIdle <= curIdle;
        if (idx <= LAST) cnt <= idx + 1'b1;
        if (strobe.hecSlot && !curIdle) altPhase <= ~altPhase;
      end
    end
  end
endmodule

// File: rtl/cellPath.sv
module cellPath
  import hdrPkg::*;
#(
  parameter int SCR_LEN = 43,
  parameter int GFC_W = 4,
  parameter logic [7:0] COSET = 8'h55,
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     strobe,
  input  logic       inValid,
  input  logic       inSoc,
  input  logic [7:0] inData,
  input  logic       gfcIn,
  output logic       outValid,
  output logic       outSoc,
  output logic [7:0] outData
);
  logic [GFC_W-1:0] gfcShift, gfcHold;
  logic [7:0] crcReg, byte0, crcNext, outByte;
  logic [SCR_LEN-1:0] scrState;
  logic [SCR_LEN+7:0] scrRes;

  function automatic logic [7:0] crcStep(logic [7:0] c, logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int b = 0; b < 8; b++) r = r[7] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  function automatic logic [SCR_LEN+7:0] scrStep(logic [SCR_LEN-1:0] st, logic [7:0] d);
    logic [7:0] o;
    for (int b = 7; b >= 0; b--) begin
      o[b] = d[b] ^ st[SCR_LEN-1];
      st = {st[SCR_LEN-2:0], o[b]};
    end
    return {st, o};
  endfunction

  assign byte0   = (strobe.first && strobe.gfcIns) ? {gfcHold, inData[7-GFC_W:0]} : inData;
  assign crcNext = crcStep(strobe.first ? 8'h00 : crcReg, byte0);
  assign scrRes  = scrStep(scrState, inData);

  always_comb begin
    outByte = byte0;
    if (strobe.hecSlot && strobe.hecIns) outByte = crcReg ^ (strobe.coset ? COSET : 8'h00);
    else if (strobe.payload && strobe.scramble) outByte = scrRes[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gfcShift <= '0;
      gfcHold  <= '0;
      crcReg   <= '0;
      scrState <= '0;
      outValid <= 1'b0;
      outSoc   <= 1'b0;
      outData  <= '0;
    end else begin
      if (strobe.hdr) begin
        crcReg   <= crcNext;
        gfcShift <= {gfcShift[GFC_W-2:0], gfcIn};
      end
      if (strobe.last) gfcHold <= gfcShift;
      if (strobe.payload && strobe.scramble) scrState <= scrRes[SCR_LEN+7:8];
      outValid <= inValid;
      outSoc   <= inValid && inSoc;
      if (inValid) outData <= outByte;
    end
  end
endmodule

// File: rtl/txcell_hdr_proc.sv
module txcell_hdr_proc
  import hdrPkg::*;
#(
  parameter int CELL_LEN = 53,
  parameter int HDR_LEN = 5,
  parameter int SCR_LEN = 43
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSoc,
  input  logic       inIdle,
  input  logic [7:0] inData,
  input  logic       gfcIn,
  output logic       outValid,
  output logic       outSoc,
  output logic [7:0] outData,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  output logic [7:0] regRdData,
  output logic       irq
);
  strobeT strobe;

  cellCtrl #(.CELL_LEN(CELL_LEN), .HDR_LEN(HDR_LEN)) i_ctrl (
    .clk, .rstN, .inValid, .inSoc, .inIdle, .inData,
    .regWrEn, .regWrData, .regRdEn, .regRdData, .irq, .strobe
  );

  cellPath #(.SCR_LEN(SCR_LEN)) i_path (
    .clk, .rstN, .strobe, .inValid, .inSoc, .inData, .gfcIn,
    .outValid, .outSoc, .outData
  );
endmodule

// File: rtl/hdrChecker.sv
module hdrChecker (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inSoc,
  input logic       regRdEn,
  input logic [7:0] regRdData,
  input logic       irq,
  input logic       outValid,
  input logic       outSoc
);
  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN) inValid |=> outValid);
  p_soc_r3: assert property (@(posedge clk) disable iff (!rstN) (inValid && inSoc) |=> outSoc);
  p_set_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regRdData[0]) |-> $past(inValid));
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[0] && !regRdEn) |=> regRdData[0]);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !inValid) |=> !regRdData[0]);
  p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rstN) irq |-> regRdData[0]);
  p_irq_mask_r6: assert property (@(posedge clk) disable iff (!rstN) !regRdData[2] |-> !irq);
endmodule

bind txcell_hdr_proc hdrChecker i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inSoc(inSoc), .regRdEn(regRdEn),
  .regRdData(regRdData), .irq(irq), .outValid(outValid), .outSoc(outSoc)
);

// File: tb/test_txcell_hdr_proc.sv
module test_txcell_hdr_proc;
  logic clk = 0, rstN = 0;
  logic inValid = 0, inSoc = 0, inIdle = 0, gfcIn = 0, regWrEn = 0, regRdEn = 0;
  logic [7:0] inData = 0, regWrData = 0;
  logic outValid, outSoc, irq;
  logic [7:0] outData, regRdData;

  int checks = 0, errors = 0;
  logic [7:1] mCtrl;
  logic mStat, mAlt;
  logic [7:0] mCrc;
  logic [42:0] mScr;
  logic [3:0] mGfcSh, mGfcHold;

  always #4 clk = ~clk;

  txcell_hdr_proc i_txcell_hdr_proc (.*);

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(logic [7:0] c, logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int b = 0; b < 8; b++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  // Reference for one byte at octet i; updates model state.
  function automatic logic [7:0] model(int i, logic idle, logic [7:0] d, logic g);
    logic [7:0] o = d;
    if (i == 0 && mCtrl[3]) o = {mGfcHold, d[3:0]};
    if (i < 4) begin
      mCrc = crc8(i == 0 ? 8'h00 : mCrc, o);
      mGfcSh = {mGfcSh[2:0], g};
    end
    if (i == 4) begin
      if (!idle) begin
        if (d != ((mCtrl[4] || !mAlt) ? 8'h55 : 8'hAA)) mStat = 1;
        mAlt = ~mAlt;
      end
      if (idle ? mCtrl[1] : mCtrl[5]) o = mCrc ^ (mCtrl[6] ? 8'h55 : 8'h00);
    end
    if (i > 4 && mCtrl[7]) begin
      for (int b = 7; b >= 0; b--) begin
        o[b] = d[b] ^ mScr[42];
        mScr = {mScr[41:0], o[b]};
      end
    end
    if (i == 52) mGfcHold = mGfcSh;
    return o;
  endfunction

  function automatic logic [7:0] curPat();
    return (mCtrl[4] || !mAlt) ? 8'h55 : 8'hAA;
  endfunction

  task automatic sendCell(input logic idle, input logic goodPat);
    logic [7:0] e;
    string tag;
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      inValid = 1; inSoc = (i == 0); inIdle = idle; gfcIn = $urandom;
      inData = $urandom;
      if (i == 4 && goodPat) inData = curPat();
      e = model(i, idle, inData, gfcIn);
      tag = i == 0 ? "R9" : i < 4 ? "R11" : i == 4 ? "R7_R8" : "R10";
      @(posedge clk); #1;
      check(outValid && outSoc == (i == 0), "R3", {6'b0, outValid, outSoc}, {6'b0, 1'b1, i == 0});
      check(outData == e, tag, outData, e);
    end
    @(negedge clk); inValid = 0; inSoc = 0;
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk); regWrEn = 1; regWrData = v;
    @(posedge clk); #1 regWrEn = 0; mCtrl = v[7:1];
  endtask

  task automatic readReg(input string tag);
    @(negedge clk); regRdEn = 1; #1;
    check(regRdData == {mCtrl, mStat}, tag, regRdData, {mCtrl, mStat});
    check(irq == (mCtrl[2] & mStat), "R6", {7'b0, irq}, {7'b0, mCtrl[2] & mStat});
    @(posedge clk); #1 regRdEn = 0; mStat = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=00 exp=01");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mCtrl = 7'b1111001; mStat = 0; mAlt = 0; mCrc = 0; mScr = 0; mGfcSh = 0; mGfcHold = 0;
    repeat (3) @(posedge clk); #1 rstN = 1;
    #1 check(regRdData == 8'hF2, "R1", regRdData, 8'hF2);
    check(!outValid && !irq, "R1", {6'b0, outValid, irq}, 8'h00);
    // R2: bit 0 of write data is ignored
    writeReg(8'hF7);
    readReg("R2");
    // R4 constant pattern, good then bad; R5 sticky and read clear
    sendCell(0, 1);
    readReg("R4");
    sendCell(0, 0);
    readReg("R4");
    readReg("R5");
    // R4 alternating mode with an idle cell between valid cells
    writeReg(8'hE6);
    sendCell(0, 1);
    sendCell(1, 0);
    sendCell(0, 1);
    readReg("R4");
    // R7/R8: insert off for valid, coset off, flow control on
    writeReg(8'h0E);
    sendCell(0, 1);
    sendCell(1, 1);
    writeReg(8'h3A);
    sendCell(0, 0);
    readReg("R6");
    // random mix
    for (int n = 0; n < 60; n++) begin
      if (n % 6 == 0) writeReg($urandom);
      sendCell($urandom_range(0, 3) == 0, $urandom_range(0, 4) != 0);
      if (n % 4 == 0) readReg("R5");
    end
    readReg("R5");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule